// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a dual-port memory. It holds an address register that can be loaded from external address inputs. After a load it steps forward on its own while a count enable is high, so a burst needs no further external addresses. A mask register picks which low-order bits take part in counting. Bits under mask ones count, and bits under mask zeros keep their loaded value. The mask therefore sets the block size at which the burst wraps back to its base.

An active-low interrupt pulses when an increment drives the counted field to all ones. A retransmit input sends the counter back to the last loaded address, so the same block can be played again. A counter/mask select input steers clear and load to either the counter or the mask register. The same select chooses which of the two values a readback request returns. Readback comes out on a separate output with its own valid strobe. There is no back-pressure on that path: a request always returns its value one cycle later. Every other pin is a plain level, sampled on the rising clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset the counter and the memory address are 0, the mask is all ones, `cnt_int_n` is 1 and `rb_valid` is 0.
- R2: `clr` with `sel_mask`=0 sets the counter to 0 at the next edge. It takes priority over load, retransmit and increment.
- R3: `ld_stb` with `sel_mask`=0 and no `clr` loads the counter from `addr_in` and saves that value as the retransmit start. It takes priority over retransmit and increment.
- R4: `cnt_en` with no other active control adds one within the bits where the mask is 1. Bits where the mask is 0 keep their value.
- R5: When the masked field is all ones, the next increment wraps that field to zero. Bits above the field do not change.
- R6: `cnt_int_n` is 0 for exactly the one cycle after an increment that makes the masked field all ones. A zero mask gives no count change and no interrupt. Loads and retransmits never raise the interrupt.
- R7: `retx` (with no clear or load) returns the counter to the last loaded address. It takes priority over `cnt_en`.
- R8: With `sel_mask`=1, `ld_stb` writes `addr_in` into the mask, and `clr` sets the mask to all ones, with `clr` winning. The counter holds in that cycle, even if `retx` or `cnt_en` is high.
- R9: `rb_req` makes `rb_valid` 1 in the next cycle. `rb_data` then holds the counter value (`sel_mask`=0) or the mask value (`sel_mask`=1) as it stood during the request cycle.
- R10: With no control active, the counter and `mem_addr` hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_mask | input | 1 | 0: clear, load and readback act on the counter; 1: on the mask |
| ld_stb | input | 1 | Load strobe |
| clr | input | 1 | Clear (counter to 0, mask to all ones) |
| retx | input | 1 | Return the counter to the last loaded address |
| cnt_en | input | 1 | Increment enable |
| addr_in | input | AW | External address or mask value |
| rb_req | input | 1 | Readback request |
| mem_addr | output | AW | Address driven to the memory array |
| cnt_int_n | output | 1 | Active-low pulse when the masked field reaches all ones |
| rb_valid | output | 1 | Readback data is valid |
| rb_data | output | AW | Readback value |

## Verification
A wrong counter or mask value shows on `mem_addr` at the first edge after the faulty operation. A wrong mask may show only at the next increment, as a step that touches a bit it should not, a missed wrap, or a missing or early interrupt pulse. A wrong retransmit start register stays hidden until the next `retx`, and then shows on `mem_addr` within one cycle. Readback makes a wrong mask visible directly, one cycle after a request.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CLR,
    OP_LOAD,
    OP_HOLD,
    OP_RETX,
    OP_INC
  } ctr_op_e;

  function automatic ctr_op_e decode_op(input logic sel_mask, input logic clr,
                                         input logic ld, input logic retx,
                                         input logic en);
    if (clr && !sel_mask)      return OP_CLR;
    else if (ld && !sel_mask)  return OP_LOAD;
    else if (clr || ld)        return OP_HOLD;
    else if (retx)             return OP_RETX;
    else if (en)               return OP_INC;
    else                       return OP_IDLE;
  endfunction
endpackage

// File: rtl/bag_mask_reg.sv
module bag_mask_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_mask,
  input  logic          clr,
  input  logic          ld,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] mask
);
  localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mask <= ALL_ONES;
    else if (sel_mask && clr)  mask <= ALL_ONES;
    else if (sel_mask && ld)   mask <= din;
  end
endmodule

// File: rtl/bag_ctr_core.sv
module bag_ctr_core
  import bag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctr_op_e       op,
  input  logic [AW-1:0] din,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] cnt,
  output logic          int_n
);
  localparam logic [AW-1:0] ZERO = '0;

  logic [AW-1:0] start_q;
  logic [AW-1:0] bumped;
  logic [AW-1:0] stepped;
  logic          hit_top;

  always_comb begin
    bumped  = cnt + 1'b1;
    stepped = (cnt & ~mask) | (bumped & mask);
    hit_top = (mask != ZERO) && ((stepped & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= ZERO;
      start_q <= ZERO;
      int_n   <= 1'b1;
    end else begin
      int_n <= 1'b1;
      unique case (op)
        OP_CLR:  cnt <= ZERO;
        OP_LOAD: begin
          cnt     <= din;
          start_q <= din;
        end
        OP_RETX: cnt <= start_q;
        OP_INC: begin
          cnt   <= stepped;
          int_n <= ~hit_top;
        end
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/bag_readback.sv
module bag_readback #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          sel_mask,
  input  logic [AW-1:0] cnt,
  input  logic [AW-1:0] mask,
  output logic          valid,
  output logic [AW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= req;
      if (req) data <= sel_mask ? mask : cnt;
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_mask,
  input  logic          ld_stb,
  input  logic          clr,
  input  logic          retx,
  input  logic          cnt_en,
  input  logic [AW-1:0] addr_in,
  input  logic          rb_req,
  output logic [AW-1:0] mem_addr,
  output logic          cnt_int_n,
  output logic          rb_valid,
  output logic [AW-1:0] rb_data
);
  ctr_op_e       op;
  logic [AW-1:0] mask_q;
  logic [AW-1:0] cnt_q;

  always_comb op = decode_op(sel_mask, clr, ld_stb, retx, cnt_en);

  bag_mask_reg #(.AW(AW)) u_mask (
    .clk(clk), .rst_n(rst_n), .sel_mask(sel_mask), .clr(clr),
    .ld(ld_stb), .din(addr_in), .mask(mask_q)
  );

  bag_ctr_core #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .op(op), .din(addr_in), .mask(mask_q),
    .cnt(cnt_q), .int_n(cnt_int_n)
  );

  bag_readback #(.AW(AW)) u_rb (
    .clk(clk), .rst_n(rst_n), .req(rb_req), .sel_mask(sel_mask),
    .cnt(cnt_q), .mask(mask_q), .valid(rb_valid), .data(rb_data)
  );

  assign mem_addr = cnt_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_mask,
  input logic          ld_stb,
  input logic          clr,
  input logic          retx,
  input logic          cnt_en,
  input logic [AW-1:0] addr_in,
  input logic          rb_req,
  input logic [AW-1:0] mem_addr,
  input logic          cnt_int_n,
  input logic          rb_valid,
  input logic [AW-1:0] mask_q
);
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !sel_mask) |=> (mem_addr == '0)); // R2

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && !sel_mask && !clr) |=> (mem_addr == $past(addr_in))); // R3

  AST_MASKED_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr && !ld_stb && !retx) |=>
      ((mem_addr & ~mask_q) == ($past(mem_addr) & ~$past(mask_q)))); // R4

  AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_int_n |=> cnt_int_n); // R6

  AST_MASK_OP_HOLDS_CTR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mask && (clr || ld_stb)) |=> $stable(mem_addr)); // R8

  AST_RB_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rb_req |=> rb_valid); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld_stb && !retx && !cnt_en) |=> $stable(mem_addr)); // R10
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_mask(sel_mask), .ld_stb(ld_stb), .clr(clr),
  .retx(retx), .cnt_en(cnt_en), .addr_in(addr_in), .rb_req(rb_req),
  .mem_addr(mem_addr), .cnt_int_n(cnt_int_n), .rb_valid(rb_valid),
  .mask_q(mask_q)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_mask = 1'b0, ld_stb = 1'b0, clr = 1'b0, retx = 1'b0;
  logic          cnt_en = 1'b0, rb_req = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] mem_addr, rb_data;
  logic          cnt_int_n, rb_valid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .sel_mask(sel_mask), .ld_stb(ld_stb), .clr(clr),
    .retx(retx), .cnt_en(cnt_en), .addr_in(addr_in), .rb_req(rb_req),
    .mem_addr(mem_addr), .cnt_int_n(cnt_int_n), .rb_valid(rb_valid),
    .rb_data(rb_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, results are read at the next falling edge.
  task automatic cyc(input logic s, input logic c, input logic l, input logic r,
                     input logic e, input logic [AW-1:0] a, input logic q);
    sel_mask = s; clr = c; ld_stb = l; retx = r; cnt_en = e; addr_in = a; rb_req = q;
    @(posedge clk);
    @(negedge clk);
    sel_mask = 0; clr = 0; ld_stb = 0; retx = 0; cnt_en = 0; rb_req = 0; addr_in = '0;
  endtask

  task automatic t_reset();
    chk("R1 addr", mem_addr, 0);
    chk("R1 int", cnt_int_n, 1);
    chk("R1 rb_valid", rb_valid, 0);
    cyc(1, 0, 0, 0, 0, '0, 1);
    chk("R1 mask all ones", rb_data, 16'hFFFF);
    chk("R9 valid", rb_valid, 1);
    cyc(0, 0, 0, 0, 0, '0, 0);
    chk("R9 valid drops", rb_valid, 0);
  endtask

  task automatic t_load_inc();
    cyc(0, 0, 1, 0, 1, 16'h1230, 0);
    chk("R3 load", mem_addr, 16'h1230);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, '0, 0);
    chk("R4 full-mask count", mem_addr, 16'h1233);
    cyc(0, 0, 0, 0, 0, 16'hBEEF, 0);
    chk("R10 idle hold", mem_addr, 16'h1233);
    cyc(0, 0, 0, 0, 0, '0, 1);
    chk("R9 counter readback", rb_data, 16'h1233);
  endtask

  task automatic t_wrap();
    cyc(1, 0, 1, 0, 0, 16'h0003, 0);
    chk("R8 mask load holds ctr", mem_addr, 16'h1233);
    cyc(0, 0, 1, 0, 0, 16'h0AB1, 0);
    cyc(0, 0, 0, 0, 1, '0, 0);
    chk("R4 masked step", mem_addr, 16'h0AB2);
    chk("R6 no early int", cnt_int_n, 1);
    cyc(0, 0, 0, 0, 1, '0, 0);
    chk("R4 step to top", mem_addr, 16'h0AB3);
    chk("R6 int low", cnt_int_n, 0);
    cyc(0, 0, 0, 0, 1, '0, 0);
    chk("R5 wrap", mem_addr, 16'h0AB0);
    chk("R6 int one cycle", cnt_int_n, 1);
  endtask

  task automatic t_retx();
    cyc(0, 0, 0, 0, 1, '0, 0);
    cyc(0, 0, 0, 1, 1, '0, 0);
    chk("R7 retransmit over inc", mem_addr, 16'h0AB1);
    cyc(0, 0, 0, 0, 1, '0, 0);
    cyc(0, 0, 0, 1, 0, '0, 0);
    chk("R7 retransmit", mem_addr, 16'h0AB1);
    cyc(0, 0, 0, 0, 0, 16'h0AB3, 0);
    chk("R6 retx no int", cnt_int_n, 1);
  endtask

  task automatic t_priority();
    cyc(0, 1, 1, 1, 1, 16'h5555, 0);
    chk("R2 clear wins", mem_addr, 0);
    cyc(0, 0, 1, 1, 1, 16'h7777, 0);
    chk("R3 load over retx", mem_addr, 16'h7777);
    cyc(0, 1, 0, 0, 0, '0, 0);
    cyc(0, 0, 0, 1, 0, '0, 0);
    chk("R3 start saved", mem_addr, 16'h7777);
  endtask

  task automatic t_mask_ops();
    cyc(1, 1, 1, 1, 1, 16'h000F, 0);
    chk("R8 mask clear holds ctr", mem_addr, 16'h7777);
    cyc(1, 0, 0, 0, 0, '0, 1);
    chk("R8 clear wins, mask ones", rb_data, 16'hFFFF);
    cyc(1, 0, 1, 0, 0, 16'h0000, 0);
    cyc(0, 0, 0, 0, 1, '0, 0);
    chk("R6 zero mask no count", mem_addr, 16'h7777);
    chk("R6 zero mask no int", cnt_int_n, 1);
    cyc(1, 0, 0, 0, 0, '0, 1);
    chk("R9 mask readback", rb_data, 16'h0000);
  endtask

  initial begin
    #1;
    t_reset_wait();
  end

  task automatic t_reset_wait();
    repeat (2) @(negedge clk);
    chk("R1 in reset", mem_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_inc();
    t_wrap();
    t_retx();
    t_priority();
    t_mask_ops();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule